// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single accumulator. It runs every instruction through fetch, decode and execute phases one after the other. It never overlaps two instructions. The datapath has explicit registers: a program counter, a memory address register (MAR), a memory data register (MDR), an instruction register and the accumulator. Every memory access travels through MAR and MDR in a fixed order of steps.

The core drives a synchronous single-port memory that returns read data one cycle after it samples the address. It also has a data input port, an output port with a one-cycle valid strobe, and a start-address input that is used at reset.

Decode checks the opcode against the instruction set. An opcode that is not in the set stops the core and raises the fault output, which stays high until the next reset. A dedicated halt instruction also stops the core, but it leaves the fault output low.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and after it is released, the program counter starts at `start_addr`, the accumulator reads 0, and the fault output is low. No write strobe and no output strobe appear during reset.
- R2: An instruction starts with a fetch-start cycle. In the following cycle `mem_addr` carries the program counter value. The returned word goes to MDR and is then copied to the instruction register, and decode follows in the fifth cycle of the instruction.
- R3: Each fetch adds exactly one to the program counter, so instructions that run in sequence are fetched from consecutive addresses.
- R4: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the operand. The legal opcodes are 0x0 halt, 0x1 load, 0x2 store, 0x3 add memory, 0x4 subtract memory, 0x5 input, 0x6 output, 0xB add immediate and 0xC subtract immediate. Bit 15 is the immediate-mode bit.
- R5: Load puts the operand address on `mem_addr` in the second execute cycle. The accumulator takes the returned word.
- R6: Store raises `mem_we` for exactly one cycle, in the third execute cycle. In that cycle `mem_addr` equals the operand and `mem_wdata` equals the accumulator.
- R7: Add and subtract combine the accumulator with a second value and wrap modulo 2^16. In memory mode the second value is the word read from the operand address. In immediate mode it is the operand, zero-extended.
- R8: Input copies `in_data` into the accumulator.
- R9: Output presents the accumulator on `out_data`, with `out_valid` high for exactly one cycle. That cycle is the first cycle of the next instruction.
- R10: An illegal opcode raises `fault` from the cycle after decode. The fault stays high until reset, with no further write, output or address change.
- R11: The halt instruction stops all activity and keeps `fault` low.
- R12: Instructions take fixed numbers of cycles: 6 for input, output and the immediate arithmetic, 9 for load and for memory add and subtract, and 8 for store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | 12 | Address of the first instruction, taken at reset |
| mem_addr | output | 12 | Memory address, driven from MAR |
| mem_wdata | output | 16 | Memory write data, driven from MDR |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 16 | Input port value |
| out_data | output | 16 | Output port value |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |
| fault | output | 1 | High while stopped on an illegal opcode |

## Verification
The bench uses the default parameters: a 16-bit word, a 4-bit opcode and a 12-bit address. Programs can therefore be placed at arbitrary start addresses, and the largest immediate, 0xFFF, fits in the operand. With these widths, subtracting a larger memory word wraps the accumulator through zero, and adding 0xFFFF is the same as subtracting one, so R7 is tested across the modulo boundary. Three programs run, each with its own reset. The first covers every legal opcode and a store that is read back. The second and third stop on illegal words, one with an unassigned opcode and one with the immediate bit set on a load. The third also confirms that the accumulator and the fault output are cleared by the reset between programs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADDM  = 4'h3,
        OP_SUBM  = 4'h4,
        OP_IN    = 4'h5,
        OP_OUT   = 4'h6,
        OP_ADDI  = 4'hB,
        OP_SUBI  = 4'hC
    } opcode_e;

    typedef enum logic [3:0] {
        PH_FSTART, PH_FREAD, PH_FCAPT, PH_FLOAD, PH_DECODE,
        PH_XADDR, PH_XREAD, PH_XCAPT, PH_XAPPLY,
        PH_SDATA, PH_SWRITE, PH_QUICK,
        PH_HALTED, PH_FAULTED
    } phase_e;

    typedef enum logic [2:0] {
        CL_QUICK, CL_READ, CL_WRITE, CL_STOP, CL_BAD
    } op_class_e;

    typedef enum logic [1:0] {
        ACC_KEEP, ACC_ALU, ACC_MDR, ACC_PORT
    } acc_sel_e;

    typedef struct packed {
        op_class_e cls;
        acc_sel_e  acc_sel;
        logic      sub;
        logic      emit;
    } decode_t;

    function automatic logic opc_is_imm(input logic [OPC_W-1:0] opc);
        return opc[OPC_W-1];
    endfunction

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output decode_t          dec
);
    always_comb begin
        dec = '{cls: CL_BAD, acc_sel: ACC_KEEP, sub: 1'b0, emit: 1'b0};
        case (opc)
            OP_HALT:  dec.cls = CL_STOP;
            OP_LOAD:  begin dec.cls = CL_READ;  dec.acc_sel = ACC_MDR; end
            OP_STORE: dec.cls = CL_WRITE;
            OP_ADDM:  begin dec.cls = CL_READ;  dec.acc_sel = ACC_ALU; end
            OP_SUBM:  begin dec.cls = CL_READ;  dec.acc_sel = ACC_ALU; dec.sub = 1'b1; end
            OP_IN:    begin dec.cls = CL_QUICK; dec.acc_sel = ACC_PORT; end
            OP_OUT:   begin dec.cls = CL_QUICK; dec.emit = 1'b1; end
            OP_ADDI:  begin dec.cls = CL_QUICK; dec.acc_sel = ACC_ALU; end
            OP_SUBI:  begin dec.cls = CL_QUICK; dec.acc_sel = ACC_ALU; dec.sub = 1'b1; end
            default:  dec.cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);
    always_comb y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  decode_t dec,
    output phase_e  ph
);
    phase_e ph_nx;

    always_comb begin
        ph_nx = ph;
        case (ph)
            PH_FSTART: ph_nx = PH_FREAD;
            PH_FREAD:  ph_nx = PH_FCAPT;
            PH_FCAPT:  ph_nx = PH_FLOAD;
            PH_FLOAD:  ph_nx = PH_DECODE;
            PH_DECODE: begin
                case (dec.cls)
                    CL_QUICK: ph_nx = PH_QUICK;
                    CL_READ,
                    CL_WRITE: ph_nx = PH_XADDR;
                    CL_STOP:  ph_nx = PH_HALTED;
                    default:  ph_nx = PH_FAULTED;
                endcase
            end
            PH_XADDR:  ph_nx = (dec.cls == CL_WRITE) ? PH_SDATA : PH_XREAD;
            PH_XREAD:  ph_nx = PH_XCAPT;
            PH_XCAPT:  ph_nx = PH_XAPPLY;
            PH_XAPPLY: ph_nx = PH_FSTART;
            PH_SDATA:  ph_nx = PH_SWRITE;
            PH_SWRITE: ph_nx = PH_FSTART;
            PH_QUICK:  ph_nx = PH_FSTART;
            default:   ph_nx = ph;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_FSTART;
        else     ph <= ph_nx;
    end

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FAULTED) |=> (ph == PH_FAULTED));
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HALTED) |=> (ph == PH_HALTED));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              fault
);
    localparam int OPND_W = DATA_W - OPC_W;

    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] mdr, ir, acc, alu_b, alu_y;
    logic [OPND_W-1:0] operand;
    decode_t           dec;
    phase_e            ph;

    assign operand = ir[OPND_W-1:0];
    assign alu_b   = (ph == PH_QUICK) ? {{OPC_W{1'b0}}, operand} : mdr;

    acc_cpu_decode u_dec (.opc(ir[DATA_W-1 -: OPC_W]), .dec(dec));
    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (.a(acc), .b(alu_b), .sub(dec.sub), .y(alu_y));
    acc_cpu_seq u_seq (.clk(clk), .rst(rst), .dec(dec), .ph(ph));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= start_addr;
            mar       <= '0;
            mdr       <= '0;
            ir        <= '0;
            acc       <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (ph)
                PH_FSTART: mar <= pc;
                PH_FCAPT:  mdr <= mem_rdata;
                PH_FLOAD:  begin ir <= mdr; pc <= pc + 1'b1; end
                PH_XADDR:  mar <= operand[ADDR_W-1:0];
                PH_XCAPT:  mdr <= mem_rdata;
                PH_XAPPLY: acc <= (dec.acc_sel == ACC_MDR) ? mdr : alu_y;
                PH_SDATA:  mdr <= acc;
                PH_QUICK: begin
                    if (dec.acc_sel == ACC_ALU)  acc <= alu_y;
                    if (dec.acc_sel == ACC_PORT) acc <= in_data;
                    if (dec.emit) begin
                        out_valid <= 1'b1;
                        out_data  <= acc;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = (ph == PH_SWRITE);
    assign fault     = (ph == PH_FAULTED);

    p_mar_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FSTART) |=> (mem_addr == $past(pc)));
    p_ir_from_mdr_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FLOAD) |=> (ir == $past(mdr)));
    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FLOAD) |=> (pc == $past(pc) + 1'b1));
    p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_we && !out_valid));
    p_fault_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (fault && $past(fault)) |-> $stable(mem_addr));
endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] start_addr = 12'h000;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = 16'h0;
    logic        mem_we;
    logic [15:0] in_data = 16'h1234;
    logic [15:0] out_data;
    logic        out_valid, fault;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    acc_cpu u0 (.clk(clk), .rst(rst), .start_addr(start_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .fault(fault));

    logic [15:0] mem [0:4095];
    logic [15:0] rm  [0:4095];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // expected values for the current cycle
    bit          chk_on = 0;
    bit          e_we = 0, e_ov = 0, e_fault = 0, e_achk = 0;
    logic [11:0] e_addr = 0;
    logic [15:0] e_wd = 0, e_od = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_on) begin
        check(mem_we === e_we, "R6 R12", "mem_we", {15'b0, mem_we}, {15'b0, e_we});
        if (e_we) check(mem_wdata === e_wd, "R6", "mem_wdata", mem_wdata, e_wd);
        if (e_achk) check(mem_addr === e_addr, "R2 R3 R5 R6", "mem_addr",
                          {4'b0, mem_addr}, {4'b0, e_addr});
        check(out_valid === e_ov, "R9 R12", "out_valid", {15'b0, out_valid}, {15'b0, e_ov});
        if (e_ov) check(out_data === e_od, "R7 R8 R9", "out_data", out_data, e_od);
        check(fault === e_fault, "R10 R11", "fault", {15'b0, fault}, {15'b0, e_fault});
    end

    task automatic put(input logic [11:0] a, input logic [15:0] w);
        mem[a] = w;
        rm[a]  = w;
    endtask

    task automatic nxt();
        @(posedge clk);
    endtask

    // behavioural instruction-level model with cycle timing per class
    task automatic run_model(input logic [11:0] vec);
        logic [11:0] pc = vec;
        logic [15:0] acc = 16'h0;
        logic [15:0] w;
        logic [3:0]  op;
        logic [11:0] opd;
        bit          pend = 0;
        logic [15:0] pend_d = 0;
        bit          stop = 0;
        while (!stop) begin
            e_ov = pend; e_od = pend_d; pend = 0;
            e_we = 0; e_achk = 0;
            nxt();
            e_ov = 0; e_achk = 1; e_addr = pc;
            nxt();
            e_achk = 0;
            w = rm[pc]; pc = pc + 1'b1;
            op = w[15:12]; opd = w[11:0];
            nxt(); nxt(); nxt();
            case (op)
                4'h5: begin acc = in_data; nxt(); end
                4'h6: begin pend = 1; pend_d = acc; nxt(); end
                4'hB: begin acc = acc + {4'h0, opd}; nxt(); end
                4'hC: begin acc = acc - {4'h0, opd}; nxt(); end
                4'h1, 4'h3, 4'h4: begin
                    nxt();
                    e_achk = 1; e_addr = opd;
                    nxt();
                    e_achk = 0;
                    nxt(); nxt();
                    if (op == 4'h1)      acc = rm[opd];
                    else if (op == 4'h3) acc = acc + rm[opd];
                    else                 acc = acc - rm[opd];
                end
                4'h2: begin
                    nxt(); nxt();
                    e_we = 1; e_achk = 1; e_addr = opd; e_wd = acc; rm[opd] = acc;
                    nxt();
                    e_we = 0; e_achk = 0;
                end
                4'h0: begin
                    e_achk = 1; e_addr = pc - 1'b1;
                    repeat (20) nxt();
                    stop = 1;
                end
                default: begin
                    e_fault = 1; e_achk = 1; e_addr = pc - 1'b1;
                    repeat (20) nxt();
                    stop = 1;
                end
            endcase
        end
    endtask

    task automatic do_reset(input logic [11:0] vec);
        chk_on = 0;
        @(negedge clk);
        rst = 1; start_addr = vec;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(fault === 1'b0, "R1", "fault in reset", {15'b0, fault}, 16'h0);
        check(mem_we === 1'b0, "R1", "mem_we in reset", {15'b0, mem_we}, 16'h0);
        check(out_valid === 1'b0, "R1", "out_valid in reset", {15'b0, out_valid}, 16'h0);
        e_we = 0; e_ov = 0; e_fault = 0; e_achk = 0;
        rst = 0;
        chk_on = 1;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = 16'h0; rm[i] = 16'h0; end
        // data words
        put(12'h050, 16'h0007);
        put(12'h051, 16'hFFFF);
        // program A: every legal opcode (R4 R5 R6 R7 R8 R9)
        put(12'h100, 16'h5000); // IN
        put(12'h101, 16'h6000); // OUT
        put(12'h102, 16'hB005); // ADD #5
        put(12'h103, 16'h2300); // STORE 0x300
        put(12'h104, 16'h1050); // LOAD 0x050
        put(12'h105, 16'h4300); // SUB mem, wraps below zero
        put(12'h106, 16'h6000); // OUT
        put(12'h107, 16'h3051); // ADD 0xFFFF
        put(12'h108, 16'hCFFF); // SUB #0xFFF
        put(12'h109, 16'h6000); // OUT
        put(12'h10A, 16'h1300); // LOAD back the stored word
        put(12'h10B, 16'h6000); // OUT
        put(12'h10C, 16'h0000); // HALT (R11)
        put(12'h10D, 16'h6000); // must not run
        // program B: unassigned opcode (R10)
        put(12'h200, 16'hB00A);
        put(12'h201, 16'h6000);
        put(12'h202, 16'h7123);
        put(12'h203, 16'h6000);
        // program C: accumulator cleared by reset (R1), immediate bit on load (R10)
        put(12'h210, 16'h6000);
        put(12'h211, 16'h9050);
        put(12'h212, 16'h2400);

        do_reset(12'h100);
        run_model(12'h100);
        do_reset(12'h200);
        run_model(12'h200);
        check(fault === 1'b1, "R10", "fault held before reset", {15'b0, fault}, 16'h1);
        do_reset(12'h210);
        check(fault === 1'b0, "R1", "fault cleared by reset", {15'b0, fault}, 16'h0);
        run_model(12'h210);
        chk_on = 0;
        check(mem[12'h300] === 16'h1239, "R6", "stored word", mem[12'h300], 16'h1239);
        check(mem[12'h400] === 16'h0000, "R10", "no store after fault", mem[12'h400], 16'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule